// File: doc/BRIEF.md
# LIN Status and Error Flag Unit

This unit gathers the event indications produced by a LIN protocol engine and holds them as sticky flags that software reads and clears. The engine reports single-cycle pulses: a header has been received, a frame has ended (completed or aborted), a bit error occurred, plus a small vector of other protocol errors. The unit also watches the raw receive line and, using a one-cycle bit-time tick, detects a bus held in the dominant (low) state for too long. That detector raises its flag again at a shorter interval for as long as the bus stays dominant.

Whether a received header is reported depends on the filter configuration. With identifier filtering off, every header is reported. With filtering on, a header is only reported when software has to handle the identifier itself, or when a transmit-type filter matched. Software sees two 16-bit words through a plain read/write port. Every flag is write-one-to-clear, and a hardware set in the same cycle as a software clear wins. There is no streaming data path here: all pins are plain control and status signals, so no valid/ready handshake applies.

Top module: `lin_flag_unit`

## Requirements
- R1: After reset both words read as zero (`reg_sel`=0 gives the status word, `reg_sel`=1 gives the error word).
- R2: With `filt_en`=0, a `hdr_done` pulse sets the header flag (status word bit 0). The flag can be read in the cycle after the pulse and stays set until it is cleared.
- R3: With `filt_en`=1, `hdr_done` sets the header flag in exactly three cases. The first is `filt_bypass`=1 with `filt_any_active`=0. The second is `filt_bypass`=1 with `filt_match`=0. The third is `filt_match_tx`=1. In every other case the flag stays 0.
- R4: The header flag is held at 0 while `init_mode`=1 and is cleared by a `frame_end` pulse. Both hardware clears take priority over a simultaneous `hdr_done`.
- R5: The stuck flag (error bit 15) is set on the 100th consecutive `bit_tick` during which `rx_line` is 0.
- R6: If the line stays dominant, the stuck flag is set again after each further 87 such ticks (the 187th tick, the 274th tick, and so on). Any cycle with `rx_line`=1 restarts the count, so the next flag again needs 100 ticks.
- R7: `bit_err` sets the bit-error flag (error bit 13) when `tx_phase`=2'b10 (response) in either role, or when `tx_phase`=2'b01 (header) with `tx_master`=1. In all other cases it is ignored (`tx_phase`=2'b00 means idle).
- R8: Writing with `reg_wr`=1 clears each flag whose `reg_wdata` bit is 1 and leaves flags whose bit is 0 unchanged. Error bits 6..1 are reserved and always read 0.
- R9: If a hardware set and a software clear of the same flag fall in the same cycle, the flag ends up set.
- R10: `misc_err[7:0]` sets error bits in this order: [7] output-compare (bit 14), [6] checksum (bit 12), [5] sync field (bit 11), [4] break delimiter (bit 10), [3] identifier parity (bit 9), [2] framing (bit 8), [1] overrun (bit 7), [0] noise (bit 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_mode | input | 1 | Engine is in initialization mode |
| bit_tick | input | 1 | One pulse per bit time |
| rx_line | input | 1 | Raw bus receive line (0 = dominant) |
| hdr_done | input | 1 | Valid header received pulse |
| frame_end | input | 1 | Frame completed or aborted pulse |
| filt_en | input | 1 | Identifier filtering enabled |
| filt_bypass | input | 1 | Bypass-filter configuration bit |
| filt_any_active | input | 1 | At least one filter is active |
| filt_match | input | 1 | Some filter matched the identifier |
| filt_match_tx | input | 1 | The matching filter is transmit-type |
| bit_err | input | 1 | Bit error detected pulse |
| tx_master | input | 1 | Node is master |
| tx_phase | input | 2 | 00 idle, 01 header transmit, 10 response transmit |
| misc_err | input | 8 | Other error event pulses (see R10) |
| reg_wr | input | 1 | Write-one-to-clear strobe |
| reg_sel | input | 1 | Word select: 0 status, 1 error |
| reg_wdata | input | 16 | Clear mask |
| reg_rdata | output | 16 | Selected word |

## Verification
A wrong dominant-time count in the stuck detector stays hidden until the 100th dominant tick. At that point the stuck flag appears one or more ticks early or late, or it does not rearm on the 87-tick spacing, so the bench walks the line through the whole 274-tick sequence and also through a recessive restart. A broken header gate shows at the status word in the cycle after `hdr_done`, which is why each filter case is driven on its own. Priority mistakes show in the cycle right after the collision: a flag lost when set and clear meet, or a header flag that survives a frame end. The bench's model is compared against the selected word on every clock, so any divergence is reported within one cycle of the edge that caused it.

// File: rtl/lin_flag_pkg.sv
package lin_flag_pkg;
  localparam int WORD_W = 16;
  localparam int MISC_W = 8;

  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_HDR  = 2'b01,
    PH_RESP = 2'b10
  } tx_phase_e;

  // error word positions (software decodes these)
  localparam int POS_STUCK = 15;
  localparam int POS_OCMP  = 14;
  localparam int POS_BITER = 13;
  localparam int POS_CKSUM = 12;
  localparam int POS_SYNC  = 11;
  localparam int POS_DELIM = 10;
  localparam int POS_PAR   = 9;
  localparam int POS_FRM   = 8;
  localparam int POS_OVR   = 7;
  localparam int POS_NOISE = 0;

  localparam logic [WORD_W-1:0] LIVE_MASK = 16'hFF81;
endpackage

// File: rtl/lin_w1c_bit.sv
module lin_w1c_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_clr,
  input  logic hw_set,
  input  logic sw_clr,
  output logic q
);
  // priority: hardware clear, hardware set, software clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= 1'b0;
    else if (hw_clr) q <= 1'b0;
    else if (hw_set) q <= 1'b1;
    else if (sw_clr) q <= 1'b0;
  end

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set && !hw_clr) |=> q);

  assert_w1c_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clr && !hw_set && !hw_clr) |=> !q);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_clr && !hw_clr && q) |=> q);
endmodule

// File: rtl/lin_dom_watch.sv
module lin_dom_watch #(
  parameter int FIRST  = 100,
  parameter int REPEAT = 87
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx,
  input  logic tick,
  output logic fire
);
  localparam int LIM_MAX = (FIRST > REPEAT) ? FIRST : REPEAT;
  localparam int CW      = $clog2(LIM_MAX + 1);

  logic [CW-1:0] cnt;
  logic          rearm;
  logic [CW-1:0] lim;

  assign lim  = rearm ? CW'(REPEAT) : CW'(FIRST);
  assign fire = tick && !rx && (cnt == lim - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      rearm <= 1'b0;
    end else if (rx) begin
      cnt   <= '0;
      rearm <= 1'b0;
    end else if (tick) begin
      if (fire) begin
        cnt   <= '0;
        rearm <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < lim);

  generate
    if (FIRST > 1) begin : g_restart_chk
      assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx |=> !fire);
    end
  endgenerate
endmodule

// File: rtl/lin_hdr_gate.sv
module lin_hdr_gate (
  input  logic hdr_done,
  input  logic filt_en,
  input  logic filt_bypass,
  input  logic filt_any_active,
  input  logic filt_match,
  input  logic filt_match_tx,
  output logic hdr_set
);
  logic sw_filter_needed;
  logic report;

  always_comb begin
    sw_filter_needed = filt_bypass && (!filt_any_active || !filt_match);
    report           = !filt_en || sw_filter_needed || filt_match_tx;
    hdr_set          = hdr_done && report;
  end
endmodule

// File: rtl/lin_flag_unit.sv
module lin_flag_unit
  import lin_flag_pkg::*;
#(
  parameter int SZ_FIRST  = 100,
  parameter int SZ_REPEAT = 87
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init_mode,
  input  logic        bit_tick,
  input  logic        rx_line,
  input  logic        hdr_done,
  input  logic        frame_end,
  input  logic        filt_en,
  input  logic        filt_bypass,
  input  logic        filt_any_active,
  input  logic        filt_match,
  input  logic        filt_match_tx,
  input  logic        bit_err,
  input  logic        tx_master,
  input  logic [1:0]  tx_phase,
  input  logic [7:0]  misc_err,
  input  logic        reg_wr,
  input  logic        reg_sel,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata
);
  logic              hdr_set, hdr_q, hdr_hw_clr;
  logic              stuck_fire, biterr_set;
  logic [WORD_W-1:0] err_set, err_clr, err_q;
  tx_phase_e         phase;
  logic              unused_wbits;

  assign unused_wbits = ^reg_wdata[WORD_W-1:1] ^ reg_wdata[0];

  lin_hdr_gate u_gate (
    .hdr_done        (hdr_done),
    .filt_en         (filt_en),
    .filt_bypass     (filt_bypass),
    .filt_any_active (filt_any_active),
    .filt_match      (filt_match),
    .filt_match_tx   (filt_match_tx),
    .hdr_set         (hdr_set)
  );

  assign hdr_hw_clr = init_mode || frame_end;

  lin_w1c_bit u_hdr (
    .clk    (clk),
    .rst_n  (rst_n),
    .hw_clr (hdr_hw_clr),
    .hw_set (hdr_set),
    .sw_clr (reg_wr && !reg_sel && reg_wdata[0]),
    .q      (hdr_q)
  );

  lin_dom_watch #(.FIRST(SZ_FIRST), .REPEAT(SZ_REPEAT)) u_dom (
    .clk   (clk),
    .rst_n (rst_n),
    .rx    (rx_line),
    .tick  (bit_tick),
    .fire  (stuck_fire)
  );

  always_comb begin
    phase      = tx_phase_e'(tx_phase);
    biterr_set = bit_err && ((phase == PH_RESP) || (phase == PH_HDR && tx_master));
    err_set            = '0;
    err_set[POS_STUCK] = stuck_fire;
    err_set[POS_OCMP]  = misc_err[7];
    err_set[POS_BITER] = biterr_set;
    err_set[POS_CKSUM] = misc_err[6];
    err_set[POS_SYNC]  = misc_err[5];
    err_set[POS_DELIM] = misc_err[4];
    err_set[POS_PAR]   = misc_err[3];
    err_set[POS_FRM]   = misc_err[2];
    err_set[POS_OVR]   = misc_err[1];
    err_set[POS_NOISE] = misc_err[0];
    err_clr = (reg_wr && reg_sel) ? reg_wdata : '0;
  end

  generate
    for (genvar i = 0; i < WORD_W; i++) begin : g_err
      if (LIVE_MASK[i]) begin : g_live
        lin_w1c_bit u_bit (
          .clk    (clk),
          .rst_n  (rst_n),
          .hw_clr (1'b0),
          .hw_set (err_set[i]),
          .sw_clr (err_clr[i]),
          .q      (err_q[i])
        );
      end else begin : g_rsv
        assign err_q[i] = 1'b0;
      end
    end
  endgenerate

  assign reg_rdata = reg_sel ? err_q : {{(WORD_W-1){1'b0}}, hdr_q};

  assert_hdr_hwclr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (init_mode || frame_end) |=> !hdr_q);

  assert_biterr_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_err && tx_phase == 2'b00 && !err_q[POS_BITER]) |=> !err_q[POS_BITER]);

  assert_stuck_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stuck_fire |=> err_q[POS_STUCK]);
endmodule

// File: tb/lin_flag_unit_test.sv
`timescale 1ns/1ps
module lin_flag_unit_test;
  logic clk = 0, rst_n = 0;
  logic init_mode = 0, bit_tick = 0, rx_line = 1, hdr_done = 0, frame_end = 0;
  logic filt_en = 0, filt_bypass = 0, filt_any_active = 0, filt_match = 0, filt_match_tx = 0;
  logic bit_err = 0, tx_master = 0;
  logic [1:0] tx_phase = 2'b00;
  logic [7:0] misc_err = 8'h00;
  logic reg_wr = 0, reg_sel = 0;
  logic [15:0] reg_wdata = 16'h0000;
  logic [15:0] reg_rdata;

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit done = 0;

  always #4 clk = ~clk; // 125 MHz

  lin_flag_unit uut (.*);

  // behavioural reference model
  logic        m_hdr = 0;
  logic [15:0] m_err = 16'h0000;
  int          n_dom = 0;

  always @(posedge clk) begin
    logic hs, fire, bs;
    logic [15:0] sets, clr;
    if (!rst_n) begin
      m_hdr = 0; m_err = 0; n_dom = 0;
    end else begin
      hs = hdr_done && (!filt_en || (filt_bypass && !filt_any_active) ||
                        (filt_bypass && !filt_match) || filt_match_tx);
      if (init_mode || frame_end) m_hdr = 0;
      else if (hs) m_hdr = 1;
      else if (reg_wr && !reg_sel && reg_wdata[0]) m_hdr = 0;
      fire = 0;
      if (rx_line) n_dom = 0;
      else if (bit_tick) begin
        n_dom++;
        fire = (n_dom == 100) || (n_dom > 100 && (n_dom - 100) % 87 == 0);
      end
      bs = bit_err && (tx_phase == 2'b10 || (tx_phase == 2'b01 && tx_master));
      sets = {fire, misc_err[7], bs, misc_err[6:1], 6'b0, misc_err[0]};
      clr  = (reg_wr && reg_sel) ? (reg_wdata & 16'hFF81) : 16'h0;
      m_err = (m_err & ~clr) | sets;
    end
  end

  always @(posedge clk) begin
    logic [15:0] exp;
    #3;
    if (rst_n && !done) begin
      exp = reg_sel ? m_err : {15'b0, m_hdr};
      checks++;
      if (reg_rdata !== exp) begin
        errors++;
        $display("FAIL %s model compare: got %h expected %h", cur_req, reg_rdata, exp);
      end
    end
  end

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input logic sel, input string req, input logic [15:0] exp);
    @(negedge clk); reg_sel = sel; #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    @(negedge clk); reg_sel = sel; reg_wr = 1; reg_wdata = d;
    @(negedge clk); reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic hdr_pulse();
    @(negedge clk); hdr_done = 1;
    @(negedge clk); hdr_done = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bit_tick = 1;
      @(negedge clk); bit_tick = 0;
    end
  endtask

  task automatic berr(input logic [1:0] ph, input logic m);
    @(negedge clk); bit_err = 1; tx_phase = ph; tx_master = m;
    @(negedge clk); bit_err = 0; tx_phase = 0; tx_master = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R1";
    rd(0, "R1 status reset", 16'h0);
    rd(1, "R1 error reset", 16'h0);

    cur_req = "R2";
    hdr_pulse();
    rd(0, "R2 header set unfiltered", 16'h1);
    repeat (3) @(negedge clk);
    rd(0, "R2 header held", 16'h1);

    cur_req = "R4";
    @(negedge clk); frame_end = 1; @(negedge clk); frame_end = 0;
    rd(0, "R4 frame end clears", 16'h0);
    hdr_pulse();
    @(negedge clk); init_mode = 1; hdr_done = 1;
    @(negedge clk); hdr_done = 0;
    rd(0, "R4 init mode holds zero", 16'h0);
    @(negedge clk); init_mode = 0;
    @(negedge clk); hdr_done = 1; frame_end = 1;
    @(negedge clk); hdr_done = 0; frame_end = 0;
    rd(0, "R4 frame end beats header", 16'h0);

    cur_req = "R3";
    filt_en = 1; filt_bypass = 1; filt_any_active = 0;
    hdr_pulse(); rd(0, "R3 bypass all inactive", 16'h1);
    wr(0, 16'h1);
    filt_any_active = 1; filt_match = 0;
    hdr_pulse(); rd(0, "R3 bypass no match", 16'h1);
    wr(0, 16'h1);
    filt_bypass = 0; filt_match = 1; filt_match_tx = 1;
    hdr_pulse(); rd(0, "R3 tx filter match", 16'h1);
    wr(0, 16'h1);
    filt_match_tx = 0;
    hdr_pulse(); rd(0, "R3 rx match suppressed", 16'h0);
    filt_bypass = 1;
    hdr_pulse(); rd(0, "R3 bypass with rx match suppressed", 16'h0);
    filt_bypass = 0; filt_match = 0;
    hdr_pulse(); rd(0, "R3 no bypass no match suppressed", 16'h0);
    filt_en = 0; filt_any_active = 0;

    cur_req = "R8";
    hdr_pulse();
    wr(0, 16'hFFFE); rd(0, "R8 write zero keeps", 16'h1);
    wr(0, 16'h0001); rd(0, "R8 write one clears", 16'h0);

    cur_req = "R5";
    reg_sel = 1;
    @(negedge clk); rx_line = 0;
    ticks(99); rd(1, "R5 no flag at 99", 16'h0);
    ticks(1);  rd(1, "R5 flag at 100", 16'h8000);
    cur_req = "R6";
    wr(1, 16'h8000);
    ticks(86); rd(1, "R6 no flag at 186", 16'h0);
    ticks(1);  rd(1, "R6 flag at 187", 16'h8000);
    wr(1, 16'h8000);
    ticks(87); rd(1, "R6 flag at 274", 16'h8000);
    wr(1, 16'h8000);
    ticks(50);
    @(negedge clk); rx_line = 1; @(negedge clk); rx_line = 0;
    ticks(99); rd(1, "R6 restart no flag at 99", 16'h0);
    ticks(1);  rd(1, "R6 restart flag at 100", 16'h8000);
    @(negedge clk); rx_line = 1;
    wr(1, 16'h8000);

    cur_req = "R7";
    berr(2'b00, 1); rd(1, "R7 idle ignored", 16'h0);
    berr(2'b01, 0); rd(1, "R7 slave header ignored", 16'h0);
    berr(2'b01, 1); rd(1, "R7 master header", 16'h2000);
    wr(1, 16'h2000);
    berr(2'b10, 0); rd(1, "R7 slave response", 16'h2000);
    wr(1, 16'h2000);

    cur_req = "R9";
    @(negedge clk); bit_err = 1; tx_phase = 2'b10; reg_wr = 1; reg_sel = 1; reg_wdata = 16'h2000;
    @(negedge clk); bit_err = 0; tx_phase = 0; reg_wr = 0; reg_wdata = 0;
    rd(1, "R9 set beats clear", 16'h2000);
    wr(1, 16'h2000);

    cur_req = "R10";
    @(negedge clk); misc_err = 8'hFF; @(negedge clk); misc_err = 8'h00;
    rd(1, "R10 field positions", 16'h5F81);
    @(negedge clk); misc_err = 8'h04; @(negedge clk); misc_err = 8'h00;
    wr(1, 16'hFEFF); rd(1, "R10 framing at bit 8", 16'h0100);
    cur_req = "R8";
    wr(1, 16'hFFFF); rd(1, "R8 all cleared reserved zero", 16'h0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule